// File: doc/BRIEF.md
# ADC External Trigger Qualifier

This block turns a raw external start pin into a clean, single-cycle request to start an A/D conversion. The pin first crosses into the peripheral clock domain through a small synchroniser. A run-length filter then measures how long the synchronised pin has held its present level and how long it held the level before that. A level trigger (low or high) needs a long steady hold. An edge trigger (falling or rising) needs a shorter steady hold on both sides of the transition. When the filtered event matches the programmed condition, the trigger path is enabled, the selected source is the external pin, and the conversion sequencer is idle, the block emits one start pulse.

The source select is sampled only while the trigger path is disabled, so changing it under a live trigger has no effect. Triggers that arrive while the sequencer reports busy are discarded, not stored. A level that is still held after a scan completes starts a further scan once the filter still sees it as qualified.

Top module: `adc_trig_qualifier`

## Requirements
- R1: The condition input selects the event: 2'b00 low level, 2'b01 high level, 2'b10 falling edge, 2'b11 rising edge. In every mode, bit 0 gives the level the synchronised pin must show when the pulse is generated.
- R2: In a level mode, a start pulse is produced only after the synchronised pin has shown the active level for 8 consecutive clocks. With the pin changed just before clock edge E0 and then held, the pulse is high in the cycle after edge E9.
- R3: In an edge mode, a start pulse is produced only when the synchronised pin held the old level for at least 4 clocks and then holds the new level for 4 clocks. The pulse is high in the cycle after edge E5, counting from the raw change as in R2. An edge yields at most one pulse.
- R4: Any change of the synchronised pin restarts the hold count, so a glitch shorter than the hold time produces no pulse.
- R5: Only source select 2'b00 (external pin) can produce a pulse. The reserved values 2'b01, 2'b10 and 2'b11 never do.
- R6: The source select is captured only while the enable is 0. Changes made while the enable is 1 are ignored until the enable next drops.
- R7: No pulse is produced while the trigger enable is 0.
- R8: A qualified event that occurs while the sequencer busy input is 1 is dropped and is not delivered later.
- R9: In a level mode, a level still held and qualified after busy falls produces a further pulse.
- R10: The start pulse is never high for two consecutive cycles.
- R11: During and right after reset the start pulse is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | 1 | Unsynchronised external start pin |
| trig_en | input | 1 | Trigger path enable |
| trig_cond | input | 2 | Event condition (see R1) |
| trig_src | input | 2 | Source select, 2'b00 = external pin |
| seq_busy | input | 1 | Conversion sequencer busy |
| start_pulse | output | 1 | One-cycle conversion start request |

## Verification
The bench targets glitches one cycle shorter than each hold time. A filter that fails to restart its count on a change would fire on such a glitch. It checks edges preceded by a too-short old level, which a design tracking only the new level would accept. It also checks events landing in a busy window, which a queueing design would deliver late, and source-select writes made under a live enable, which a transparent select would obey. A held level across several scans must re-fire after each busy period and never during one, and a design missing the in-flight guard would emit a two-cycle pulse.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  typedef enum logic [1:0] {
    COND_LOW  = 2'b00,
    COND_HIGH = 2'b01,
    COND_FALL = 2'b10,
    COND_RISE = 2'b11
  } trig_cond_e;

  localparam logic [1:0] SRC_EXT_PIN = 2'b00;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n[0] = d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_comb begin
        chain_n[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_n;
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/adc_trig_runlen.sv
module adc_trig_runlen #(
  parameter int LEVEL_HOLD = 8,
  parameter int EDGE_HOLD  = 4,
  localparam int CNT_W     = $clog2(LEVEL_HOLD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level_in,
  output logic [CNT_W-1:0] run_now,
  output logic [CNT_W-1:0] run_prior
);
  localparam logic [CNT_W-1:0] SAT_RUN  = CNT_W'(LEVEL_HOLD);
  localparam logic [CNT_W-1:0] SAT_OLD  = CNT_W'(EDGE_HOLD);
  localparam logic [CNT_W-1:0] ONE_RUN  = CNT_W'(1);

  logic             level_q;
  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] prior_q;
  logic             changed;
  logic             adv_en;
  logic [CNT_W-1:0] run_n;
  logic [CNT_W-1:0] prior_n;

  always_comb begin
    changed = level_in ^ level_q;
    adv_en  = 1'b1;
    if (changed) begin
      run_n   = ONE_RUN;
      prior_n = (run_q >= SAT_OLD) ? SAT_OLD : run_q;
    end else begin
      run_n   = (run_q >= SAT_RUN) ? SAT_RUN : run_q + ONE_RUN;
      prior_n = prior_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      run_q   <= '0;
      prior_q <= '0;
    end else if (adv_en) begin
      level_q <= level_in;
      run_q   <= run_n;
      prior_q <= prior_n;
    end
  end

  assign run_now   = run_n;
  assign run_prior = prior_n;
endmodule

// File: rtl/adc_trig_qualifier.sv
module adc_trig_qualifier
  import adc_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LEVEL_HOLD  = 8,
  parameter int EDGE_HOLD   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_raw,
  input  logic       trig_en,
  input  logic [1:0] trig_cond,
  input  logic [1:0] trig_src,
  input  logic       seq_busy,
  output logic       start_pulse
);
  localparam int CNT_W = $clog2(LEVEL_HOLD + 1);
  localparam logic [CNT_W-1:0] LVL_MIN  = CNT_W'(LEVEL_HOLD);
  localparam logic [CNT_W-1:0] EDGE_MIN = CNT_W'(EDGE_HOLD);

  logic             rst_core_n;
  logic             pin_sync;
  logic [CNT_W-1:0] run_now;
  logic [CNT_W-1:0] run_prior;
  logic [1:0]       src_q;
  logic [1:0]       src_n;
  logic             src_en;
  logic             start_q;
  logic             start_n;
  logic             at_target;
  logic             level_ok;
  logic             edge_ok;
  logic             blocked;
  trig_cond_e       cond;

  // Reset: asserted asynchronously, released after the synchroniser depth
  adc_trig_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_core_n)
  );

  adc_trig_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .d     (pin_raw),
    .q     (pin_sync)
  );

  adc_trig_runlen #(
    .LEVEL_HOLD (LEVEL_HOLD),
    .EDGE_HOLD  (EDGE_HOLD)
  ) u_runlen (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .level_in  (pin_sync),
    .run_now   (run_now),
    .run_prior (run_prior)
  );

  always_comb begin
    cond      = trig_cond_e'(trig_cond);
    // bit 0 of the condition is the level seen when the event completes
    at_target = (pin_sync == trig_cond[0]);
    level_ok  = 1'b0;
    edge_ok   = 1'b0;
    unique case (cond)
      COND_LOW, COND_HIGH: level_ok = at_target && (run_now >= LVL_MIN);
      COND_FALL, COND_RISE: edge_ok = at_target && (run_now == EDGE_MIN)
                                      && (run_prior >= EDGE_MIN);
      default: ;
    endcase
    blocked = seq_busy | start_q;
    start_n = (level_ok | edge_ok) && trig_en && (src_q == SRC_EXT_PIN) && !blocked;
    src_en  = !trig_en;
    src_n   = trig_src;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      src_q <= SRC_EXT_PIN;
    end else if (src_en) begin
      src_q <= src_n;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      start_q <= 1'b0;
    end else begin
      start_q <= start_n;
    end
  end

  assign start_pulse = start_q;
endmodule

// File: rtl/adc_trig_qualifier_chk.sv
module adc_trig_qualifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       trig_en,
  input logic [1:0] trig_cond,
  input logic       seq_busy,
  input logic       start_pulse,
  input logic       pin_sync,
  input logic [1:0] src_q
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse); // R10

  AST_NO_FIRE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(trig_en)); // R7

  AST_NO_FIRE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !$past(seq_busy)); // R8

  AST_SRC_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> ($past(src_q) == 2'b00)); // R5

  AST_SRC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_en && $past(trig_en)) |-> $stable(src_q)); // R6

  AST_TARGET_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> ($past(pin_sync) == $past(trig_cond[0]))); // R1
endmodule

bind adc_trig_qualifier adc_trig_qualifier_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .trig_en     (trig_en),
  .trig_cond   (trig_cond),
  .seq_busy    (seq_busy),
  .start_pulse (start_pulse),
  .pin_sync    (pin_sync),
  .src_q       (src_q)
);

// File: tb/tb_adc_trig_qualifier.sv
module tb_adc_trig_qualifier;
  localparam int LH = 8;
  localparam int EH = 4;

  logic       clk;
  logic       rst_n;
  logic       pin_raw;
  logic       trig_en;
  logic [1:0] trig_cond;
  logic [1:0] trig_src;
  logic       seq_busy;
  logic       start_pulse;

  int checks;
  int failures;
  int pulses;
  bit done;
  bit auto_busy;
  bit force_busy;
  int busy_left;
  string tag;

  // reference state
  logic m_s1, m_y, m_yq, m_src, m_start, m_prev_start;
  int   m_run, m_prior;
  logic [1:0] m_srcq;

  adc_trig_qualifier dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_raw     (pin_raw),
    .trig_en     (trig_en),
    .trig_cond   (trig_cond),
    .trig_src    (trig_src),
    .seq_busy    (seq_busy),
    .start_pulse (start_pulse)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int min_i(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_s1 = pin_raw; m_y = pin_raw; m_yq = pin_raw;
    m_run = LH; m_prior = 0; m_srcq = trig_src;
    m_start = 1'b0; m_prev_start = 1'b0;
  endtask

  // one clock: advance reference with held inputs, compare, then update busy
  task automatic tick();
    bit ch, lvl, edg, fire;
    int run_n, prior_n;
    @(negedge clk);
    ch      = (m_y != m_yq);
    run_n   = ch ? 1 : min_i(m_run + 1, LH);
    prior_n = ch ? min_i(m_run, EH) : m_prior;
    lvl  = !trig_cond[1] && (m_y == trig_cond[0]) && (run_n >= LH);
    edg  = trig_cond[1] && (m_y == trig_cond[0]) && (run_n == EH) && (prior_n >= EH);
    fire = (lvl || edg) && trig_en && (m_srcq == 2'b00) && !seq_busy && !m_start;
    m_prev_start = m_start;
    m_start = fire;
    if (!trig_en) m_srcq = trig_src;
    m_yq = m_y; m_run = run_n; m_prior = prior_n; m_y = m_s1; m_s1 = pin_raw;
    check(start_pulse === m_start, tag, int'(start_pulse), int'(m_start));
    if (m_prev_start && start_pulse) check(1'b0, "R10", 1, 0);
    if (start_pulse) pulses++;
    if (busy_left > 0) busy_left--;
    if (auto_busy && start_pulse) busy_left = 3 + int'($urandom_range(0, 6));
    seq_busy = force_busy || (busy_left > 0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(200_000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_ADC1));
    checks = 0; failures = 0; pulses = 0; done = 0;
    auto_busy = 1; force_busy = 0; busy_left = 0; tag = "R11";
    rst_n = 1'b0; pin_raw = 1'b0; trig_en = 1'b0;
    trig_cond = 2'b00; trig_src = 2'b00; seq_busy = 1'b0;
    repeat (3) @(negedge clk);
    check(start_pulse === 1'b0, "R11", int'(start_pulse), 0);
    rst_n = 1'b1;
    repeat (16) @(negedge clk);
    check(start_pulse === 1'b0, "R11", int'(start_pulse), 0);
    model_reset();

    // R2: high level, exact latency
    tag = "R2"; trig_cond = 2'b01; trig_en = 1'b1; ticks(2);
    pin_raw = 1'b1; pulses = 0;
    ticks(9);
    check(pulses == 0, "R2", pulses, 0);
    tick();
    check(start_pulse === 1'b1, "R2", int'(start_pulse), 1);
    ticks(3);

    // R9: held level re-fires after busy
    tag = "R9"; pulses = 0; ticks(40);
    check(pulses >= 2, "R9", pulses, 2);
    pin_raw = 1'b0; trig_en = 1'b0; ticks(12);

    // R4: glitches shorter than hold in rising-edge and high-level modes
    tag = "R4"; trig_cond = 2'b11; trig_en = 1'b1; pulses = 0;
    pin_raw = 1'b1; ticks(3); pin_raw = 1'b0; ticks(10);
    trig_cond = 2'b01; pin_raw = 1'b1; ticks(7); pin_raw = 1'b0; ticks(10);
    check(pulses == 0, "R4", pulses, 0);

    // R3: rising edge latency; short old level rejected
    tag = "R3"; trig_cond = 2'b11; pulses = 0;
    pin_raw = 1'b1; ticks(5);
    check(start_pulse === 1'b0, "R3", int'(start_pulse), 0);
    tick();
    check(start_pulse === 1'b1, "R3", int'(start_pulse), 1);
    ticks(10);
    check(pulses == 1, "R3", pulses, 1);
    pin_raw = 1'b0; ticks(3); pin_raw = 1'b1; ticks(12);
    check(pulses == 1, "R3", pulses, 1);

    // R1: falling edge and low level
    tag = "R1"; trig_cond = 2'b10; pulses = 0;
    pin_raw = 1'b0; ticks(12);
    check(pulses == 1, "R1", pulses, 1);
    trig_en = 1'b0; ticks(2); trig_cond = 2'b00; pulses = 0; trig_en = 1'b1; ticks(12);
    check(pulses >= 1, "R1", pulses, 1);
    trig_en = 1'b0; ticks(12);

    // R5: reserved source never fires
    tag = "R5"; pulses = 0; trig_src = 2'b10; ticks(2); trig_en = 1'b1;
    trig_cond = 2'b01; pin_raw = 1'b1; ticks(20);
    check(pulses == 0, "R5", pulses, 0);
    trig_en = 1'b0; pin_raw = 1'b0; ticks(12);

    // R6: change of source while enabled is ignored
    tag = "R6"; trig_src = 2'b00; ticks(2); trig_en = 1'b1; ticks(1);
    trig_src = 2'b11; pulses = 0; pin_raw = 1'b1; ticks(20);
    check(pulses >= 1, "R6", pulses, 1);
    trig_en = 1'b0; pin_raw = 1'b0; ticks(2); trig_src = 2'b00; ticks(12);

    // R7: disabled path stays silent
    tag = "R7"; pulses = 0; trig_cond = 2'b01; pin_raw = 1'b1; ticks(20);
    check(pulses == 0, "R7", pulses, 0);
    pin_raw = 1'b0; ticks(12);

    // R8: edge during busy is dropped, not delivered later
    tag = "R8"; trig_cond = 2'b11; trig_en = 1'b1; pulses = 0;
    force_busy = 1'b1; ticks(1); pin_raw = 1'b1; ticks(10);
    force_busy = 1'b0; ticks(15);
    check(pulses == 0, "R8", pulses, 0);
    pin_raw = 1'b0; ticks(12);

    // random mix
    tag = "R1";
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 9) == 0) begin
        trig_en = 1'b0; ticks(1);
        trig_cond = 2'($urandom_range(0, 3));
        trig_src  = ($urandom_range(0, 4) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
        ticks(1); trig_en = 1'b1;
      end
      if ($urandom_range(0, 19) == 0) trig_src = 2'($urandom_range(0, 3));
      force_busy = ($urandom_range(0, 7) == 0);
      pin_raw = 1'($urandom_range(0, 1));
      ticks(1 + int'($urandom_range(0, 11)));
    end
    force_busy = 1'b0;
    ticks(5);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule